// File: doc/BRIEF.md
# Memory-Mapped System Bus Decoder

This block sits between a byte-wide CPU port and everything that CPU can address in a 64 KiB space. Every request carries a 16-bit address, a write flag and a data byte. The upper address byte picks one of six destinations: general RAM, a preloaded ROM, a text display register window, a keyboard register window, a disk controller window, or a reserved hole. RAM and ROM are held inside the block. The display and keyboard windows are small register files, also inside the block. The disk window is passed out as a strobe with a local offset, and the bus keeps none of the disk's data.

Every read completes exactly one cycle after its request, flagged by a read-valid pulse, whatever the target. A reserved address returns zero and raises a one-cycle fault pulse. The display turns data writes into a character/valid pair and keeps a screen cursor that wraps at the end of the screen. The keyboard side buffers key codes from a push port in a small FIFO, and reading its data register takes the oldest code out.

The implemented RAM and ROM depths are parameters. Addresses inside each window alias onto the implemented depth through their low bits.

Top module: `sysbus_decoder`

## Requirements
- R1: A read request returns `rd_valid` high with `rd_data` in the next cycle. A write never raises `rd_valid`. Addresses 0x0000-0xBFFF reach RAM, and a RAM read returns the last byte written to that address.
- R2: Addresses 0xE000-0xEFFF reach ROM. The ROM is preloaded so that the byte at local offset o equals o[7:0] XOR 0x5A. With the default `ROM_WRITABLE = 0`, a write to ROM leaves its contents unchanged.
- R3: The reserved ranges are 0xC000-0xDFFF and 0xF400-0xFFFF. An access there raises `fault` for one cycle, in the cycle after the request. A read there returns 0x00, and a write there is dropped.
- R4: Display offset 0 (0xF000) is the mode register. It resets to 0x00, a write stores the byte, and a read returns it. Mode value 0x01 means TTY and any other value means off.
- R5: A write to display offset 1 while the mode is 0x01 gives `tty_valid` high for one cycle in the next cycle, with `tty_char` equal to the byte written, and advances `tty_cursor` by one. In any other mode the write produces no output and leaves the cursor unchanged.
- R6: `tty_cursor` resets to 0. After position `TTY_COLS*TTY_ROWS-1` it wraps to 0.
- R7: Reads of display offsets other than 0 return 0x00.
- R8: Keyboard offset 0 (0xF100) reads 0x01 when at least one key code is queued and 0x00 otherwise.
- R9: Keyboard offset 1 (0xF101) reads return queued codes oldest first and remove each one. A read of an empty queue returns 0x00.
- R10: The key queue holds `KBD_DEPTH` (default 8) codes. A `kbd_push` into a full queue is dropped.
- R11: Writes anywhere in the keyboard window change neither the queue nor the status.
- R12: For 0xF200-0xF3FF, `disk_sel` is high in the request cycle with `disk_off` = address minus 0xF200, and `disk_we`/`disk_wdata` follow the request. A read returns the `disk_rdata` value sampled in the request cycle. `disk_sel` stays low for every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 8 | Read data |
| fault | output | 1 | One-cycle pulse after a reserved-range access |
| kbd_push | input | 1 | Push a key code into the queue |
| kbd_code | input | 8 | Key code to push |
| tty_valid | output | 1 | Character emitted this cycle |
| tty_char | output | 8 | Emitted character |
| tty_cursor | output | $clog2(TTY_COLS*TTY_ROWS) | Cursor position after the last character |
| disk_sel | output | 1 | Disk window strobe (request cycle) |
| disk_we | output | 1 | Disk access is a write |
| disk_off | output | DISK_OFF_W | Offset inside the disk window |
| disk_wdata | output | 8 | Disk write data |
| disk_rdata | input | 8 | Disk read data, sampled in the request cycle |

## Verification
The embedded properties watch, on every cycle, the one-cycle read timing, the zero data and the request that must precede each fault pulse, the key queue never holding more than its depth or losing its fill level when full or empty, and the display only emitting in TTY mode with the cursor stepping and staying inside the screen. Data correctness depends on history and can only be shown by the directed scenarios. This covers RAM readback, the ROM pattern surviving a write, FIFO ordering and drop-on-full, keyboard writes being ignored, the cursor wrap after a full screen, and the disk offset and data pass-through.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;

  typedef enum logic [2:0] {
    RG_RAM,
    RG_ROM,
    RG_DISP,
    RG_KBD,
    RG_DISK,
    RG_RSVD
  } region_e;

  localparam logic [7:0] TTY_MODE = 8'h01;

  // Page (upper address byte) to destination; order of tests matters.
  function automatic region_e page_region(input logic [7:0] pg);
    if (pg < 8'hC0)       return RG_RAM;
    else if (pg < 8'hE0)  return RG_RSVD;
    else if (pg < 8'hF0)  return RG_ROM;
    else if (pg == 8'hF0) return RG_DISP;
    else if (pg == 8'hF1) return RG_KBD;
    else if (pg == 8'hF2 || pg == 8'hF3) return RG_DISK;
    else                  return RG_RSVD;
  endfunction

endpackage

// File: rtl/sysbus_addr_decode.sv
module sysbus_addr_decode
  import sysbus_pkg::*;
(
  input  logic [7:0] page,
  output region_e    region
);

  always_comb region = page_region(page);

endmodule

// File: rtl/sysbus_mem.sv
module sysbus_mem #(
  parameter int         AW       = 10,
  parameter int         DW       = 8,
  parameter bit         WRITABLE = 1'b1,
  parameter bit         PRELOAD  = 1'b0,
  parameter logic [7:0] SEED     = 8'h5A
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  generate
    if (PRELOAD) begin : g_preload
      initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i) ^ DW'(SEED);
      end
    end

    if (WRITABLE) begin : g_wr
      always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
      end
    end else begin : g_ro
      logic unused_wr;
      assign unused_wr = ^{we, wdata};
    end
  endgenerate

  always_ff @(posedge clk) rdata <= mem[addr];

endmodule

// File: rtl/sysbus_tty.sv
module sysbus_tty
  import sysbus_pkg::*;
#(
  parameter int COLS  = 80,
  parameter int ROWS  = 25,
  localparam int CELLS = COLS * ROWS,
  localparam int CW    = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    off,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          tty_valid,
  output logic [7:0]    tty_char,
  output logic [CW-1:0] cursor
);

  localparam logic [CW-1:0] LAST = CW'(CELLS - 1);

  logic [7:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 8'h00;
      tty_valid <= 1'b0;
      tty_char  <= 8'h00;
      cursor    <= '0;
    end else begin
      tty_valid <= 1'b0;
      if (wr_en && off == 8'h00) mode_q <= wdata;
      if (wr_en && off == 8'h01 && mode_q == TTY_MODE) begin
        tty_valid <= 1'b1;
        tty_char  <= wdata;
        cursor    <= (cursor == LAST) ? '0 : cursor + 1'b1;
      end
    end
  end

  assign rdata = (off == 8'h00) ? mode_q : 8'h00;

  AST_CURSOR_RANGE: assert property (@(posedge clk) disable iff (rst)
    cursor <= LAST); // R6
  AST_TTY_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (rst)
    tty_valid |-> $past(mode_q) == TTY_MODE); // R5
  AST_CURSOR_STEPS: assert property (@(posedge clk) disable iff (rst)
    tty_valid |-> cursor != $past(cursor)); // R5

endmodule

// File: rtl/sysbus_kbd_fifo.sv
module sysbus_kbd_fifo #(
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNTW = PW + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       pop,
  output logic [7:0] head,
  output logic       not_empty
);

  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic [7:0]      slots [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic            do_push, do_pop;

  assign not_empty = (count != '0);
  assign do_push   = push && (count != FULL_CNT);
  assign do_pop    = pop && not_empty;
  assign head      = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNTW'(do_push) - CNTW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT); // R10
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (count == FULL_CNT && !pop) |=> count == FULL_CNT); // R10
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (!not_empty && !push) |=> !not_empty); // R9

endmodule

// File: rtl/sysbus_decoder.sv
module sysbus_decoder
  import sysbus_pkg::*;
#(
  parameter int RAM_AW       = 10,
  parameter int ROM_AW       = 10,
  parameter bit ROM_WRITABLE = 1'b0,
  parameter int KBD_DEPTH    = 8,
  parameter int TTY_COLS     = 80,
  parameter int TTY_ROWS     = 25,
  parameter int DISK_OFF_W   = 9
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  req_valid,
  input  logic                                  req_we,
  input  logic [15:0]                           req_addr,
  input  logic [7:0]                            req_wdata,
  output logic                                  rd_valid,
  output logic [7:0]                            rd_data,
  output logic                                  fault,
  input  logic                                  kbd_push,
  input  logic [7:0]                            kbd_code,
  output logic                                  tty_valid,
  output logic [7:0]                            tty_char,
  output logic [$clog2(TTY_COLS*TTY_ROWS)-1:0]  tty_cursor,
  output logic                                  disk_sel,
  output logic                                  disk_we,
  output logic [DISK_OFF_W-1:0]                 disk_off,
  output logic [7:0]                            disk_wdata,
  input  logic [7:0]                            disk_rdata
);

  region_e    region, rsel_q;
  logic [7:0] ram_q, rom_q, tty_rdata, kbd_head;
  logic [7:0] periph_d, periph_q;
  logic       kbd_ne, is_rd, is_wr;

  assign is_rd = req_valid && !req_we;
  assign is_wr = req_valid && req_we;

  sysbus_addr_decode u_dec (
    .page   (req_addr[15:8]),
    .region (region)
  );

  sysbus_mem #(.AW(RAM_AW), .DW(8), .WRITABLE(1'b1), .PRELOAD(1'b0)) u_ram (
    .clk   (clk),
    .we    (is_wr && region == RG_RAM),
    .addr  (req_addr[RAM_AW-1:0]),
    .wdata (req_wdata),
    .rdata (ram_q)
  );

  sysbus_mem #(.AW(ROM_AW), .DW(8), .WRITABLE(ROM_WRITABLE), .PRELOAD(1'b1)) u_rom (
    .clk   (clk),
    .we    (is_wr && region == RG_ROM),
    .addr  (req_addr[ROM_AW-1:0]),
    .wdata (req_wdata),
    .rdata (rom_q)
  );

  sysbus_tty #(.COLS(TTY_COLS), .ROWS(TTY_ROWS)) u_tty (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (is_wr && region == RG_DISP),
    .off       (req_addr[7:0]),
    .wdata     (req_wdata),
    .rdata     (tty_rdata),
    .tty_valid (tty_valid),
    .tty_char  (tty_char),
    .cursor    (tty_cursor)
  );

  sysbus_kbd_fifo #(.DEPTH(KBD_DEPTH)) u_kbd (
    .clk       (clk),
    .rst       (rst),
    .push      (kbd_push),
    .push_data (kbd_code),
    .pop       (is_rd && region == RG_KBD && req_addr[7:0] == 8'h01),
    .head      (kbd_head),
    .not_empty (kbd_ne)
  );

  // Disk window is passed straight through in the request cycle.
  assign disk_sel   = req_valid && region == RG_DISK;
  assign disk_we    = req_we;
  assign disk_off   = req_addr[DISK_OFF_W-1:0];
  assign disk_wdata = req_wdata;

  always_comb begin
    periph_d = 8'h00;
    case (region)
      RG_DISP: periph_d = tty_rdata;
      RG_KBD: begin
        if (req_addr[7:0] == 8'h00)      periph_d = {7'b0, kbd_ne};
        else if (req_addr[7:0] == 8'h01) periph_d = kbd_ne ? kbd_head : 8'h00;
      end
      RG_DISK: periph_d = disk_rdata;
      default: periph_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      fault    <= 1'b0;
      rsel_q   <= RG_RSVD;
      periph_q <= 8'h00;
    end else begin
      rd_valid <= is_rd;
      fault    <= req_valid && region == RG_RSVD;
      rsel_q   <= region;
      periph_q <= periph_d;
    end
  end

  always_comb begin
    case (rsel_q)
      RG_RAM:  rd_data = ram_q;
      RG_ROM:  rd_data = rom_q;
      default: rd_data = periph_q;
    endcase
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && !req_we)); // R1
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fault && rd_valid) |-> rd_data == 8'h00); // R3
  AST_FAULT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    fault |-> $past(req_valid)); // R3

endmodule

// File: tb/sysbus_decoder_tb_top.sv
module sysbus_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CELLS      = 80 * 25;
  localparam int CW         = $clog2(CELLS);
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [15:0]   req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          rd_valid, fault;
  logic [7:0]    rd_data;
  logic          kbd_push = 1'b0;
  logic [7:0]    kbd_code = '0;
  logic          tty_valid;
  logic [7:0]    tty_char;
  logic [CW-1:0] tty_cursor;
  logic          disk_sel, disk_we;
  logic [8:0]    disk_off;
  logic [7:0]    disk_wdata;
  logic [7:0]    disk_rdata = '0;

  int n_checks = 0;
  int n_fails  = 0;
  int exp_cur  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysbus_decoder dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .fault(fault), .kbd_push(kbd_push), .kbd_code(kbd_code),
    .tty_valid(tty_valid), .tty_char(tty_char), .tty_cursor(tty_cursor),
    .disk_sel(disk_sel), .disk_we(disk_we), .disk_off(disk_off),
    .disk_wdata(disk_wdata), .disk_rdata(disk_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  // Request driven at a falling edge, registered results sampled one falling edge later.
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d, output logic v, output logic f);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data; v = rd_valid; f = fault;
  endtask

  task automatic read_expect(input string req, input logic [15:0] a, input logic [7:0] e);
    logic [7:0] d; logic v, f;
    bus_read(a, d, v, f);
    chk({req, " rd_valid"}, int'(v), 1);
    chk({req, " data"}, int'(d), int'(e));
  endtask

  task automatic key_push(input logic [7:0] c);
    @(negedge clk);
    kbd_push = 1'b1; kbd_code = c;
    @(negedge clk);
    kbd_push = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset rd_valid", int'(rd_valid), 0);
    chk("R3 reset fault", int'(fault), 0);
    chk("R5 reset tty_valid", int'(tty_valid), 0);
    chk("R6 reset cursor", int'(tty_cursor), 0);
    chk("R12 idle disk_sel", int'(disk_sel), 0);
    read_expect("R4 reset mode", 16'hF000, 8'h00);
  endtask

  task automatic t_ram();
    bus_write(16'h0123, 8'h5C);
    chk("R1 write gives no rd_valid", int'(rd_valid), 0);
    bus_write(16'h0000, 8'h11);
    bus_write(16'h0200, 8'hE7);
    read_expect("R1 ram 0x0123", 16'h0123, 8'h5C);
    read_expect("R1 ram 0x0000", 16'h0000, 8'h11);
    bus_write(16'h0123, 8'h3A);
    read_expect("R1 ram overwrite", 16'h0123, 8'h3A);
    read_expect("R1 ram 0x0200", 16'h0200, 8'hE7);
  endtask

  task automatic t_rom();
    read_expect("R2 rom 0xE000", 16'hE000, 8'h5A);
    read_expect("R2 rom 0xE0FF", 16'hE0FF, 8'hA5);
    bus_write(16'hE010, 8'h00);
    read_expect("R2 rom write blocked", 16'hE010, 8'h4A);
  endtask

  task automatic t_rsvd();
    logic [7:0] d; logic v, f;
    bus_read(16'hC000, d, v, f);
    chk("R3 rsvd read valid", int'(v), 1);
    chk("R3 rsvd read data", int'(d), 0);
    chk("R3 rsvd read fault", int'(f), 1);
    @(negedge clk);
    chk("R3 fault one cycle", int'(fault), 0);
    bus_read(16'hFFFF, d, v, f);
    chk("R3 top rsvd fault", int'(f), 1);
    bus_write(16'hD000, 8'h77);
    chk("R3 rsvd write fault", int'(fault), 1);
    read_expect("R3 rsvd write dropped", 16'hD000, 8'h00);
    bus_read(16'hF3FF, d, v, f);
    chk("R3 disk edge no fault", int'(f), 0);
  endtask

  task automatic t_disp();
    bus_write(16'hF000, 8'h01);
    read_expect("R4 mode readback", 16'hF000, 8'h01);
    read_expect("R7 disp off 5", 16'hF005, 8'h00);
    read_expect("R7 disp off 1", 16'hF001, 8'h00);
  endtask

  task automatic t_tty();
    bus_write(16'hF000, 8'h01);
    bus_write(16'hF001, 8'h41);
    exp_cur++;
    chk("R5 tty_valid", int'(tty_valid), 1);
    chk("R5 tty_char", int'(tty_char), 8'h41);
    chk("R5 cursor step", int'(tty_cursor), exp_cur);
    @(negedge clk);
    chk("R5 tty_valid pulse", int'(tty_valid), 0);
    bus_write(16'hF000, 8'h00);
    bus_write(16'hF001, 8'h42);
    chk("R5 mode off no char", int'(tty_valid), 0);
    chk("R5 mode off cursor", int'(tty_cursor), exp_cur);
    bus_write(16'hF000, 8'h02);
    bus_write(16'hF001, 8'h43);
    chk("R5 mode 2 no char", int'(tty_valid), 0);
    read_expect("R4 mode 2 readback", 16'hF000, 8'h02);
  endtask

  task automatic t_wrap();
    bus_write(16'hF000, 8'h01);
    while (exp_cur < CELLS - 1) begin
      bus_write(16'hF001, 8'h2E);
      exp_cur++;
    end
    chk("R6 cursor at last cell", int'(tty_cursor), CELLS - 1);
    bus_write(16'hF001, 8'h21);
    exp_cur = 0;
    chk("R6 cursor wrap", int'(tty_cursor), 0);
    chk("R5 wrap char", int'(tty_char), 8'h21);
    bus_write(16'hF001, 8'h22);
    exp_cur = 1;
    chk("R6 cursor after wrap", int'(tty_cursor), 1);
  endtask

  task automatic t_kbd();
    read_expect("R8 status empty", 16'hF100, 8'h00);
    read_expect("R9 pop empty", 16'hF101, 8'h00);
    key_push(8'h31); key_push(8'h32); key_push(8'h33);
    read_expect("R8 status queued", 16'hF100, 8'h01);
    read_expect("R9 pop 1st", 16'hF101, 8'h31);
    read_expect("R9 pop 2nd", 16'hF101, 8'h32);
    read_expect("R9 pop 3rd", 16'hF101, 8'h33);
    read_expect("R8 status drained", 16'hF100, 8'h00);
    read_expect("R9 pop drained", 16'hF101, 8'h00);
  endtask

  task automatic t_kbd_full();
    for (int i = 0; i < 10; i++) key_push(8'(8'h40 + i));
    for (int i = 0; i < 8; i++) read_expect("R10 full order", 16'hF101, 8'(8'h40 + i));
    read_expect("R10 extra pushes dropped", 16'hF101, 8'h00);
  endtask

  task automatic t_kbd_wr();
    key_push(8'h55);
    bus_write(16'hF100, 8'h00);
    chk("R11 kbd write no rd_valid", int'(rd_valid), 0);
    bus_write(16'hF101, 8'h99);
    bus_write(16'hF1FF, 8'h12);
    read_expect("R11 status kept", 16'hF100, 8'h01);
    read_expect("R11 queue intact", 16'hF101, 8'h55);
    read_expect("R11 no injected code", 16'hF101, 8'h00);
  endtask

  task automatic t_disk();
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 16'hF3AB; disk_rdata = 8'hC3;
    #1;
    chk("R12 read disk_sel", int'(disk_sel), 1);
    chk("R12 read disk_off", int'(disk_off), 9'h1AB);
    chk("R12 read disk_we", int'(disk_we), 0);
    @(negedge clk);
    req_valid = 1'b0; disk_rdata = 8'h00;
    chk("R12 read data", int'(rd_data), 8'hC3);
    chk("R12 read valid", int'(rd_valid), 1);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 16'hF205; req_wdata = 8'h66;
    #1;
    chk("R12 write disk_sel", int'(disk_sel), 1);
    chk("R12 write disk_we", int'(disk_we), 1);
    chk("R12 write disk_off", int'(disk_off), 5);
    chk("R12 write data", int'(disk_wdata), 8'h66);
    req_addr = 16'h0205;
    #1;
    chk("R12 ram no disk_sel", int'(disk_sel), 0);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ram();
    t_rom();
    t_rsvd();
    t_disp();
    t_tty();
    t_wrap();
    t_kbd();
    t_kbd_full();
    t_kbd_wr();
    t_disk();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule